// File: doc/BRIEF.md
# Step Action Qualifier Unit

This unit computes one Boolean action that belongs to one step of a sequential function chart. On every scan of the controller it looks at three things: whether the step is active, whether this scan is the first one after the step was entered, and which qualifier the configuration input selects. From these it updates a single registered output. Seven qualifiers are available. A plain follower mirrors step activity. A latch pair sets or clears a stored bit. A one-scan pulse fires on entry. Three duration-based forms use an internal countdown: a time-limited pulse, a delay that needs the step to still be active, and a delay whose result is stored even after the step has been left.

The countdown advances on scan ticks, not on raw clocks, so every duration is a whole number of scan periods. Several copies can drive the same chart variable through an arbitration rule outside the block. Within one copy, switching the selector to the clearing qualifier and entering the step removes a stored value and also cancels a delayed-stored countdown that is still running.

Top module: `step_action_unit`

## Requirements
- R1: While `rst` is high, and after it, `act_out` is 0, the stored bit is clear and no countdown is running.
- R2: With `qual_sel` = 0 (follow), each scan sets `act_out` to the value of `step_active` in that scan, and nothing is kept once the step is inactive.
- R3: With `qual_sel` = 1 (set), a scan with `step_entry` high sets the stored bit; `act_out` shows the stored bit and stays 1 after the step is left.
- R4: With `qual_sel` = 2 (clear), a scan with `step_entry` high clears the stored bit and cancels any running countdown, so a delayed-stored action that was pending before never fires; `act_out` shows the stored bit.
- R5: With `qual_sel` = 3 (pulse), `act_out` is 1 for exactly one scan, the entry scan, and 0 on every other scan.
- R6: With `qual_sel` = 4 (limited), the entry scan loads the countdown with `duration`; `act_out` is 1 while the step is active and fewer than `duration` scans have passed since entry, so it is high for `duration` scans at most and never when `duration` is 0.
- R7: With `qual_sel` = 5 (delayed), `act_out` becomes 1 on the scan `duration` scans after entry (the entry scan itself when `duration` is 0) and stays 1 while the step is active; leaving the step drops `act_out` and cancels the countdown.
- R8: With `qual_sel` = 6 (delayed-stored), the countdown loaded on entry keeps running after the step is left; on the scan `duration` scans after entry the stored bit is set and `act_out` stays 1 from then on.
- R9: With `qual_sel` = 7 (inert), each scan drives `act_out` to 0.
- R10: `act_out`, the stored bit and the countdown change only on a clock edge where `scan_tick` is high; the new output appears one clock after the tick cycle and holds until the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_tick | input | 1 | One-cycle strobe marking a controller scan |
| step_active | input | 1 | The associated step is active in this scan |
| step_entry | input | 1 | This scan is the first one of the step's activity |
| qual_sel | input | 3 | Qualifier: 0 follow, 1 set, 2 clear, 3 pulse, 4 limited, 5 delayed, 6 delayed-stored, 7 inert |
| duration | input | DUR_W | Countdown length in scans, loaded on entry |
| act_out | output | 1 | Registered action value |

## Verification
Every result is due on the clock edge that closes the tick cycle. The bench drives a scan on a falling edge, lets the rising edge update the design, and compares `act_out` at the next falling edge. It then holds `scan_tick` low for a random number of clocks and checks that the output has not moved. Delay results are due `duration` scans after the entry scan, counting that scan as zero. The directed cases count scans exactly for the expiry, cancel and clear-wins situations, and random episodes compare each scan against a bench reference model.

// File: rtl/sau_pkg.sv
package sau_pkg;

    typedef enum logic [2:0] {
        Q_FOLLOW      = 3'd0,
        Q_SET         = 3'd1,
        Q_CLEAR       = 3'd2,
        Q_PULSE       = 3'd3,
        Q_LIMITED     = 3'd4,
        Q_DELAYED     = 3'd5,
        Q_DELAY_STORE = 3'd6,
        Q_INERT       = 3'd7
    } qual_e;

    typedef struct packed {
        logic load;
        logic cancel;
        logic oneshot;
    } tmr_ctl_t;

    typedef struct packed {
        logic set;
        logic clr;
    } store_ctl_t;

    function automatic logic uses_timer(qual_e q);
        return (q == Q_LIMITED) || (q == Q_DELAYED) || (q == Q_DELAY_STORE);
    endfunction

    function automatic logic needs_active(qual_e q);
        return (q == Q_LIMITED) || (q == Q_DELAYED);
    endfunction

endpackage

// File: rtl/sau_qual_decode.sv
module sau_qual_decode
    import sau_pkg::*;
(
    input  logic     scan_tick,
    input  logic     step_active,
    input  logic     step_entry,
    input  qual_e    qual,
    output tmr_ctl_t tmr_ctl,
    output logic     set_on_entry,
    output logic     clr_on_entry
);
    logic entry_scan;

    always_comb begin
        entry_scan          = scan_tick && step_entry;
        tmr_ctl.load        = entry_scan && uses_timer(qual);
        tmr_ctl.cancel      = scan_tick &&
                              ((needs_active(qual) && !step_active) ||
                               (qual == Q_CLEAR && step_entry));
        tmr_ctl.oneshot     = (qual == Q_DELAY_STORE);
        set_on_entry        = entry_scan && (qual == Q_SET);
        clr_on_entry        = entry_scan && (qual == Q_CLEAR);
    end
endmodule

// File: rtl/sau_scan_timer.sv
module sau_scan_timer
    import sau_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_tick,
    input  tmr_ctl_t         ctl,
    input  logic [DUR_W-1:0] dur,
    output logic             live_nz,
    output logic             at_zero
);
    localparam logic [DUR_W-1:0] ONE  = {{(DUR_W-1){1'b0}}, 1'b1};
    localparam logic [DUR_W-1:0] ZERO = '0;

    logic [DUR_W-1:0] rem_q, rem_d;
    logic             run_q, run_d;

    always_comb begin
        rem_d = rem_q;
        run_d = run_q;
        if (scan_tick) begin
            if (ctl.load) begin
                rem_d = dur;
                run_d = 1'b1;
            end else if (ctl.cancel) begin
                run_d = 1'b0;
            end else if (run_q && rem_q != ZERO) begin
                rem_d = rem_q - ONE;
            end
        end
    end

    assign live_nz = scan_tick && run_d && (rem_d != ZERO);
    assign at_zero = scan_tick && run_d && (rem_d == ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= ZERO;
            run_q <= 1'b0;
        end else begin
            rem_q <= rem_d;
            run_q <= run_d && !(ctl.oneshot && at_zero);
        end
    end
endmodule

// File: rtl/sau_store_latch.sv
module sau_store_latch
    import sau_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  store_ctl_t ctl,
    output logic       stored_nxt
);
    logic stored_q;

    always_comb begin
        if (ctl.clr)      stored_nxt = 1'b0;
        else if (ctl.set) stored_nxt = 1'b1;
        else              stored_nxt = stored_q;
    end

    always_ff @(posedge clk) begin
        if (rst) stored_q <= 1'b0;
        else     stored_q <= stored_nxt;
    end
endmodule

// File: rtl/step_action_unit.sv
module step_action_unit
    import sau_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_tick,
    input  logic             step_active,
    input  logic             step_entry,
    input  logic [2:0]       qual_sel,
    input  logic [DUR_W-1:0] duration,
    output logic             act_out
);
    qual_e      qual;
    tmr_ctl_t   tmr_ctl;
    store_ctl_t st_ctl;
    logic       set_on_entry, clr_on_entry;
    logic       live_nz, at_zero;
    logic       stored_nxt;
    logic       out_d;

    assign qual = qual_e'(qual_sel);

    sau_qual_decode u_dec (
        .scan_tick    (scan_tick),
        .step_active  (step_active),
        .step_entry   (step_entry),
        .qual         (qual),
        .tmr_ctl      (tmr_ctl),
        .set_on_entry (set_on_entry),
        .clr_on_entry (clr_on_entry)
    );

    sau_scan_timer #(.DUR_W(DUR_W)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .scan_tick (scan_tick),
        .ctl       (tmr_ctl),
        .dur       (duration),
        .live_nz   (live_nz),
        .at_zero   (at_zero)
    );

    always_comb begin
        st_ctl.clr = clr_on_entry;
        st_ctl.set = set_on_entry || ((qual == Q_DELAY_STORE) && at_zero);
    end

    sau_store_latch u_store (
        .clk        (clk),
        .rst        (rst),
        .ctl        (st_ctl),
        .stored_nxt (stored_nxt)
    );

    always_comb begin
        unique case (qual)
            Q_FOLLOW:      out_d = step_active;
            Q_SET,
            Q_CLEAR,
            Q_DELAY_STORE: out_d = stored_nxt;
            Q_PULSE:       out_d = step_entry;
            Q_LIMITED:     out_d = step_active && live_nz;
            Q_DELAYED:     out_d = step_active && at_zero;
            default:       out_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            act_out <= 1'b0;
        else if (scan_tick) act_out <= out_d;
    end
endmodule

// File: rtl/step_action_chk.sv
module step_action_chk #(
    parameter int DUR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             scan_tick,
    input logic             step_active,
    input logic             step_entry,
    input logic [2:0]       qual_sel,
    input logic [DUR_W-1:0] duration,
    input logic             act_out
);
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !act_out);

    assert_follow_R2: assert property (@(posedge clk) disable iff (rst)
        scan_tick && qual_sel == 3'd0 |=> act_out == $past(step_active));

    assert_set_entry_R3: assert property (@(posedge clk) disable iff (rst)
        scan_tick && qual_sel == 3'd1 && step_entry |=> act_out);

    assert_clear_entry_R4: assert property (@(posedge clk) disable iff (rst)
        scan_tick && qual_sel == 3'd2 && step_entry |=> !act_out);

    assert_pulse_once_R5: assert property (@(posedge clk) disable iff (rst)
        scan_tick && qual_sel == 3'd3 && !step_entry |=> !act_out);

    assert_limited_inactive_R6: assert property (@(posedge clk) disable iff (rst)
        scan_tick && qual_sel == 3'd4 && !step_active |=> !act_out);

    assert_delay_inactive_R7: assert property (@(posedge clk) disable iff (rst)
        scan_tick && qual_sel == 3'd5 && !step_active |=> !act_out);

    assert_store_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        scan_tick && qual_sel == 3'd6 && act_out |=> act_out);

    assert_inert_low_R9: assert property (@(posedge clk) disable iff (rst)
        scan_tick && qual_sel == 3'd7 |=> !act_out);

    assert_hold_between_R10: assert property (@(posedge clk) disable iff (rst)
        !scan_tick |=> $stable(act_out));
endmodule

bind step_action_unit step_action_chk #(.DUR_W(DUR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scan_tick   (scan_tick),
    .step_active (step_active),
    .step_entry  (step_entry),
    .qual_sel    (qual_sel),
    .duration    (duration),
    .act_out     (act_out)
);

// File: tb/test_step_action_unit.sv
`timescale 1ns/1ps
module test_step_action_unit;
    localparam int DUR_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             scan_tick = 1'b0;
    logic             step_active = 1'b0;
    logic             step_entry = 1'b0;
    logic [2:0]       qual_sel = 3'd0;
    logic [DUR_W-1:0] duration = '0;
    logic             act_out;

    int n_checks = 0;
    int n_fails  = 0;

    // reference state
    bit m_stored, m_run, m_out;
    int m_rem;

    always #5 clk = ~clk;

    step_action_unit #(.DUR_W(DUR_W)) i_step_action_unit (
        .clk(clk), .rst(rst), .scan_tick(scan_tick), .step_active(step_active),
        .step_entry(step_entry), .qual_sel(qual_sel), .duration(duration),
        .act_out(act_out)
    );

    function automatic string tag_of(logic [2:0] q);
        case (q)
            3'd0: return "R2";  3'd1: return "R3";  3'd2: return "R4";
            3'd3: return "R5";  3'd4: return "R6";  3'd5: return "R7";
            3'd6: return "R8";  default: return "R9";
        endcase
    endfunction

    task automatic check(bit exp, string tag);
        n_checks++;
        if (act_out !== exp) begin
            n_fails++;
            $display("FAIL %s: act_out=%b expected=%b at %0t", tag, act_out, exp, $time);
        end
    endtask

    task automatic model_scan(bit act, bit ent);
        bit zero, nz;
        int q = qual_sel;
        int d = duration;
        if (ent && q >= 4 && q <= 6) begin m_rem = d; m_run = 1; end
        else if ((q == 2 && ent) || ((q == 4 || q == 5) && !act)) m_run = 0;
        else if (m_run && m_rem > 0) m_rem--;
        zero = m_run && m_rem == 0;
        nz   = m_run && m_rem != 0;
        if (q == 6 && zero) m_run = 0;
        if (q == 2 && ent) m_stored = 0;
        else if ((q == 1 && ent) || (q == 6 && zero)) m_stored = 1;
        case (q)
            0: m_out = act;
            1, 2, 6: m_out = m_stored;
            3: m_out = ent;
            4: m_out = act && nz;
            5: m_out = act && zero;
            default: m_out = 0;
        endcase
    endtask

    // one scan: drive at negedge, DUT updates at posedge, check at next negedge
    task automatic scan(bit act, bit ent, int gap);
        @(negedge clk);
        step_active = act; step_entry = ent; scan_tick = 1'b1;
        model_scan(act, ent);
        @(negedge clk);
        scan_tick = 1'b0; step_entry = 1'b0;
        check(m_out, tag_of(qual_sel));
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(m_out, "R10");
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fails++;
        $display("FAIL watchdog: act_out=%b expected=finish", act_out);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        bit prev;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: output low during and after reset
        check(1'b0, "R1");
        rst = 1'b0;
        m_stored = 0; m_run = 0; m_out = 0; m_rem = 0;
        @(negedge clk);
        check(1'b0, "R1");

        // R5 pulse: one scan on entry only
        qual_sel = 3'd3;
        scan(1, 1, 1); check(1'b1, "R5");
        scan(1, 0, 0); check(1'b0, "R5");
        scan(0, 0, 0);

        // R6 limited, duration 2: high for two scans, then low
        qual_sel = 3'd4; duration = 16'd2;
        scan(1, 1, 0); check(1'b1, "R6");
        scan(1, 0, 0); check(1'b1, "R6");
        scan(1, 0, 0); check(1'b0, "R6");
        scan(0, 0, 0);
        duration = 16'd0;
        scan(1, 1, 0); check(1'b0, "R6");
        scan(0, 0, 0);

        // R7 delayed, duration 2: low, low, high; leaving drops it
        qual_sel = 3'd5; duration = 16'd2;
        scan(1, 1, 0); check(1'b0, "R7");
        scan(1, 0, 0); check(1'b0, "R7");
        scan(1, 0, 0); check(1'b1, "R7");
        scan(1, 0, 0); check(1'b1, "R7");
        scan(0, 0, 0); check(1'b0, "R7");
        // leave early: timer cancelled
        scan(1, 1, 0); scan(0, 0, 0);
        scan(0, 0, 0); scan(0, 0, 0); check(1'b0, "R7");

        // R8 delayed-stored, duration 2, step left at once
        qual_sel = 3'd6; duration = 16'd2;
        scan(1, 1, 0); check(1'b0, "R8");
        scan(0, 0, 0); check(1'b0, "R8");
        scan(0, 0, 0); check(1'b1, "R8");
        scan(0, 0, 3); check(1'b1, "R8");

        // R4 clear wins over stored value
        qual_sel = 3'd2;
        scan(1, 1, 0); check(1'b0, "R4");
        scan(0, 0, 0);
        // R4 clear cancels a pending delayed-stored countdown
        qual_sel = 3'd6; duration = 16'd3;
        scan(1, 1, 0); scan(0, 0, 0);
        qual_sel = 3'd2;
        scan(1, 1, 0);
        qual_sel = 3'd6;
        for (int k = 0; k < 5; k++) scan(0, 0, 0);
        check(1'b0, "R4");

        // R3 set survives leaving the step
        qual_sel = 3'd1;
        scan(1, 1, 0); check(1'b1, "R3");
        scan(0, 0, 2); check(1'b1, "R3");
        qual_sel = 3'd2; scan(1, 1, 0); scan(0, 0, 0);

        // R9 inert
        qual_sel = 3'd7;
        scan(1, 1, 0); check(1'b0, "R9");
        scan(0, 0, 0);

        // R2 follow
        qual_sel = 3'd0;
        scan(1, 1, 0); check(1'b1, "R2");
        scan(0, 0, 0); check(1'b0, "R2");

        // random episodes
        prev = 0;
        for (int ep = 0; ep < 400; ep++) begin
            int on_n  = $urandom_range(0, 5);
            int off_n = $urandom_range(0, 4);
            qual_sel = 3'($urandom_range(0, 7));
            duration = 16'($urandom_range(0, 4));
            for (int s = 0; s < on_n; s++) begin
                scan(1, !prev, $urandom_range(0, 2));
                prev = 1;
            end
            for (int s = 0; s < off_n; s++) begin
                scan(0, 0, $urandom_range(0, 2));
                prev = 0;
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule